// File: doc/BRIEF.md
# Column-Exclusive Grouped Event Selector

This block steers cache events onto a bank of general event counters. The event space is a grid: eight groups (columns), each carrying up to 256 codes (rows). Every group has its own event strobe that carries an 8-bit code, a one-bit origin CPU id, a "no origin id" flag and a 2-bit subunit id. A packed 64-bit selection word holds one chosen code per group, so only one code per column is live at any time. Each counter follows one group through its own type setting and screens events through its own filter. The result is one registered increment pulse per counter, issued one clock after the matching strobe.

The selection word can be loaded whole or updated one group field at a time. A field update replaces only that group's byte and arms the global enable in the top bit. That top bit is shared with the group-7 field, so group 7 keeps seven code bits. Code 0xFE is kept for a separate cycle counter and never produces an increment here. Counter storage and register address decode belong to neighbouring blocks.

Top module: `grouped_event_router`

## Requirements
- R1: After reset, sel_word is zero, every counter follows group 0 with all filter enables clear, and ctr_inc is zero.
- R2: When sel_wr_all is high, sel_word takes sel_wr_data at the next clock. This holds even when sel_fld_we is high in the same cycle.
- R3: A field update (sel_fld_we high, sel_wr_all low) writes sel_fld_code into bits 8g+7:8g of sel_word for g = sel_fld_grp, and sets bit 63. All other bits stay unchanged.
- R4: While sel_word bit 63 is clear, no counter increments.
- R5: A counter whose group is g pulses ctr_inc one clock after a strobe on group g whose code equals the code held for g and which its filter passes. A code that does not match produces no pulse.
- R6: A strobe carrying code 0xFE never produces an increment in any group.
- R7: In group 7, only codes with bit 7 clear whose low seven bits equal sel_word bits 62:56 match.
- R8: The subunit filter enables (word bits 19:17, here ctr_cfg_sub_en[2:0]) admit subunit ids 0, 1 and 2 in that order. Subunit id 3 never passes.
- R9: Origin filter enables (word bits 2:0, here ctr_cfg_org_en): bit 0 admits origin 0 and bit 1 admits origin 1. Bit 2 admits strobes with ev_noid set, and in that case the origin id is ignored.
- R10: Counters that follow the same group pulse together on the same event. Counters on different groups respond independently to simultaneous strobes.
- R11: ctr_cfg_we writes counter ctr_cfg_idx. With ctr_cfg_is_filt low it writes the group from ctr_cfg_grp. With ctr_cfg_is_filt high it writes both filter fields. The new setting governs strobes from the next clock on.
- R12: A strobe that arrives in the same cycle as a selection or counter setting write is judged against the setting in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr_all | input | 1 | Load the whole selection word |
| sel_wr_data | input | 64 | Selection word value for a whole load |
| sel_fld_we | input | 1 | Update one group field and arm the enable |
| sel_fld_grp | input | 3 | Group whose field is updated |
| sel_fld_code | input | 8 | New code for that group |
| ctr_cfg_we | input | 1 | Write one counter's setting |
| ctr_cfg_idx | input | 3 | Counter index |
| ctr_cfg_is_filt | input | 1 | 0: group setting, 1: filter setting |
| ctr_cfg_grp | input | 3 | Group the counter follows |
| ctr_cfg_sub_en | input | 3 | Subunit id 2..0 enables |
| ctr_cfg_org_en | input | 3 | No-id, origin 1, origin 0 enables |
| ev_valid | input | 8 | Per-group event strobe |
| ev_code | input | 64 | Per-group code, group g in bits 8g+7:8g |
| ev_origin | input | 8 | Per-group origin CPU id |
| ev_noid | input | 8 | Per-group flag: event carries no origin id |
| ev_sub | input | 16 | Per-group subunit id, group g in bits 2g+1:2g |
| sel_word | output | 64 | Current selection word |
| ctr_inc | output | 8 | Per-counter increment pulse |

## Verification
Two activities can fall in the same cycle: a rewrite of the selection word or a counter's group, and an event strobe that the rewrite affects. The bench drives a field update together with a strobe that carries the outgoing code. A pulse is required for that strobe, and for the new code only on the next strobe. The same is done with a counter group change. A whole load that coincides with a field update is judged by reading sel_word, which must equal the loaded value.

// File: rtl/gevr_pkg.sv
package gevr_pkg;
    localparam int CODE_W      = 8;
    localparam int NUM_GROUPS  = 8;
    localparam int SEL_W       = CODE_W * NUM_GROUPS;
    localparam int EN_BIT      = SEL_W - 1;
    localparam int GRP_IDX_W   = $clog2(NUM_GROUPS);
    localparam int SUB_ID_W    = 2;
    localparam int SUB_CLASSES = 3;
    localparam int ORG_EN_W    = 3;
    localparam logic [CODE_W-1:0] CYCLE_CODE = 8'hFE;

    typedef enum logic [SUB_ID_W-1:0] {
        SUB_CLASS_A = 2'd0,
        SUB_CLASS_B = 2'd1,
        SUB_CLASS_C = 2'd2,
        SUB_NOCLASS = 2'd3
    } sub_id_e;

    function automatic logic sub_admit(input logic [SUB_CLASSES-1:0] en,
                                       input logic [SUB_ID_W-1:0] id);
        logic ok;
        unique case (sub_id_e'(id))
            SUB_CLASS_A: ok = en[0];
            SUB_CLASS_B: ok = en[1];
            SUB_CLASS_C: ok = en[2];
            default:     ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic org_admit(input logic [ORG_EN_W-1:0] en,
                                       input logic origin,
                                       input logic noid);
        logic ok;
        if (noid)        ok = en[2];
        else if (origin) ok = en[1];
        else             ok = en[0];
        return ok;
    endfunction
endpackage

// File: rtl/gevr_sel_reg.sv
module gevr_sel_reg
    import gevr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_all,
    input  logic [SEL_W-1:0]      wr_data,
    input  logic                  fld_we,
    input  logic [GRP_IDX_W-1:0]  fld_grp,
    input  logic [CODE_W-1:0]     fld_code,
    output logic [SEL_W-1:0]      sel_q
);
    logic [SEL_W-1:0] sel_nxt;

    // Whole load outranks a field update; a field update merges one byte
    // into the held word and arms the enable bit (which overlays group 7's top bit).
    always_comb begin
        sel_nxt = sel_q;
        if (wr_all) begin
            sel_nxt = wr_data;
        end else if (fld_we) begin
            sel_nxt[{fld_grp, 3'b000} +: CODE_W] = fld_code;
            sel_nxt[EN_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_nxt;
    end
endmodule

// File: rtl/gevr_group_match.sv
module gevr_group_match
    import gevr_pkg::*;
(
    input  logic [SEL_W-1:0]      sel_q,
    input  logic [NUM_GROUPS-1:0] ev_valid,
    input  logic [SEL_W-1:0]      ev_code,
    output logic [NUM_GROUPS-1:0] grp_hit
);
    localparam int LAST = NUM_GROUPS - 1;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_col
        logic [CODE_W-1:0] code;
        logic              code_eq;
        assign code = ev_code[g*CODE_W +: CODE_W];
        if (g == LAST) begin : g_short
            // Top field shares its MSB with the enable: seven code bits only.
            assign code_eq = !code[CODE_W-1] &&
                             (code[CODE_W-2:0] == sel_q[g*CODE_W +: CODE_W-1]);
        end else begin : g_full
            assign code_eq = (code == sel_q[g*CODE_W +: CODE_W]);
        end
        assign grp_hit[g] = sel_q[EN_BIT] && ev_valid[g] && code_eq &&
                            (code != CYCLE_CODE);
    end
endmodule

// File: rtl/gevr_ctr_slice.sv
module gevr_ctr_slice
    import gevr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_is_filt,
    input  logic [GRP_IDX_W-1:0]       cfg_grp,
    input  logic [SUB_CLASSES-1:0]     cfg_sub_en,
    input  logic [ORG_EN_W-1:0]        cfg_org_en,
    input  logic [NUM_GROUPS-1:0]      grp_hit,
    input  logic [NUM_GROUPS-1:0]      ev_origin,
    input  logic [NUM_GROUPS-1:0]      ev_noid,
    input  logic [NUM_GROUPS*SUB_ID_W-1:0] ev_sub,
    output logic                       inc_o
);
    logic [GRP_IDX_W-1:0]   grp_q;
    logic [SUB_CLASSES-1:0] sub_q;
    logic [ORG_EN_W-1:0]    org_q;
    logic [SUB_ID_W-1:0]    sub_id;
    logic                   pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
            sub_q <= '0;
            org_q <= '0;
        end else if (cfg_we) begin
            if (cfg_is_filt) begin
                sub_q <= cfg_sub_en;
                org_q <= cfg_org_en;
            end else begin
                grp_q <= cfg_grp;
            end
        end
    end

    always_comb begin
        sub_id = ev_sub[{grp_q, 1'b0} +: SUB_ID_W];
        pass   = grp_hit[grp_q] &&
                 sub_admit(sub_q, sub_id) &&
                 org_admit(org_q, ev_origin[grp_q], ev_noid[grp_q]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inc_o <= 1'b0;
        else        inc_o <= pass;
    end
endmodule

// File: rtl/grouped_event_router.sv
module grouped_event_router
    import gevr_pkg::*;
#(
    parameter int NUM_CTRS = 8,
    localparam int CIDX_W  = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_wr_all,
    input  logic [SEL_W-1:0]               sel_wr_data,
    input  logic                           sel_fld_we,
    input  logic [GRP_IDX_W-1:0]           sel_fld_grp,
    input  logic [CODE_W-1:0]              sel_fld_code,
    input  logic                           ctr_cfg_we,
    input  logic [CIDX_W-1:0]              ctr_cfg_idx,
    input  logic                           ctr_cfg_is_filt,
    input  logic [GRP_IDX_W-1:0]           ctr_cfg_grp,
    input  logic [SUB_CLASSES-1:0]         ctr_cfg_sub_en,
    input  logic [ORG_EN_W-1:0]            ctr_cfg_org_en,
    input  logic [NUM_GROUPS-1:0]          ev_valid,
    input  logic [SEL_W-1:0]               ev_code,
    input  logic [NUM_GROUPS-1:0]          ev_origin,
    input  logic [NUM_GROUPS-1:0]          ev_noid,
    input  logic [NUM_GROUPS*SUB_ID_W-1:0] ev_sub,
    output logic [SEL_W-1:0]               sel_word,
    output logic [NUM_CTRS-1:0]            ctr_inc
);
    logic [NUM_GROUPS-1:0] grp_hit;

    gevr_sel_reg u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_all   (sel_wr_all),
        .wr_data  (sel_wr_data),
        .fld_we   (sel_fld_we),
        .fld_grp  (sel_fld_grp),
        .fld_code (sel_fld_code),
        .sel_q    (sel_word)
    );

    gevr_group_match u_match (
        .sel_q    (sel_word),
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .grp_hit  (grp_hit)
    );

    for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
        gevr_ctr_slice u_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_we      (ctr_cfg_we && (ctr_cfg_idx == CIDX_W'(c))),
            .cfg_is_filt (ctr_cfg_is_filt),
            .cfg_grp     (ctr_cfg_grp),
            .cfg_sub_en  (ctr_cfg_sub_en),
            .cfg_org_en  (ctr_cfg_org_en),
            .grp_hit     (grp_hit),
            .ev_origin   (ev_origin),
            .ev_noid     (ev_noid),
            .ev_sub      (ev_sub),
            .inc_o       (ctr_inc[c])
        );
    end
endmodule

// File: rtl/gevr_checker.sv
module gevr_checker
    import gevr_pkg::*;
#(
    parameter int NUM_CTRS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_wr_all,
    input  logic [SEL_W-1:0]         sel_wr_data,
    input  logic                     sel_fld_we,
    input  logic [GRP_IDX_W-1:0]     sel_fld_grp,
    input  logic [CODE_W-1:0]        sel_fld_code,
    input  logic [NUM_GROUPS-1:0]    ev_valid,
    input  logic [SEL_W-1:0]         ev_code,
    input  logic [SEL_W-1:0]         sel_word,
    input  logic [NUM_CTRS-1:0]      ctr_inc
);
    logic             only_reserved;
    logic [SEL_W-1:0] touched_q;
    logic [CODE_W-2:0] low_code_q;
    logic [GRP_IDX_W-1:0] grp_q;

    always_comb begin
        only_reserved = 1'b1;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (ev_valid[g] && (ev_code[g*CODE_W +: CODE_W] != CYCLE_CODE))
                only_reserved = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            touched_q  <= '0;
            low_code_q <= '0;
            grp_q      <= '0;
        end else begin
            touched_q  <= ({{(SEL_W-CODE_W){1'b0}}, {CODE_W{1'b1}}} << {sel_fld_grp, 3'b000})
                          | (SEL_W'(1) << EN_BIT);
            low_code_q <= sel_fld_code[CODE_W-2:0];
            grp_q      <= sel_fld_grp;
        end
    end

    AST_WHOLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_all |=> (sel_word == $past(sel_wr_data))); // R2

    AST_FIELD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fld_we && !sel_wr_all) |=> (((sel_word ^ $past(sel_word)) & ~touched_q) == '0)); // R3

    AST_FIELD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fld_we && !sel_wr_all) |=> (sel_word[EN_BIT] &&
            (sel_word[{grp_q, 3'b000} +: CODE_W-1] == low_code_q))); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_word[EN_BIT] |=> (ctr_inc == '0)); // R4

    AST_CYCLE_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        only_reserved |=> (ctr_inc == '0)); // R6
endmodule

bind grouped_event_router gevr_checker #(.NUM_CTRS(NUM_CTRS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_wr_all   (sel_wr_all),
    .sel_wr_data  (sel_wr_data),
    .sel_fld_we   (sel_fld_we),
    .sel_fld_grp  (sel_fld_grp),
    .sel_fld_code (sel_fld_code),
    .ev_valid     (ev_valid),
    .ev_code      (ev_code),
    .sel_word     (sel_word),
    .ctr_inc      (ctr_inc)
);

// File: tb/tb_grouped_event_router.sv
module tb_grouped_event_router;
    localparam int NC = 8;
    localparam int NG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr_all = 1'b0;
    logic [63:0] sel_wr_data = '0;
    logic        sel_fld_we = 1'b0;
    logic [2:0]  sel_fld_grp = '0;
    logic [7:0]  sel_fld_code = '0;
    logic        ctr_cfg_we = 1'b0;
    logic [2:0]  ctr_cfg_idx = '0;
    logic        ctr_cfg_is_filt = 1'b0;
    logic [2:0]  ctr_cfg_grp = '0;
    logic [2:0]  ctr_cfg_sub_en = '0;
    logic [2:0]  ctr_cfg_org_en = '0;
    logic [7:0]  ev_valid = '0;
    logic [63:0] ev_code = '0;
    logic [7:0]  ev_origin = '0;
    logic [7:0]  ev_noid = '0;
    logic [15:0] ev_sub = '0;
    logic [63:0] sel_word;
    logic [NC-1:0] ctr_inc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [63:0] m_sel = '0;
    logic [2:0]  m_grp [NC];
    logic [2:0]  m_sub [NC];
    logic [2:0]  m_org [NC];

    always #10 clk = ~clk;

    grouped_event_router #(.NUM_CTRS(NC)) dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected pulses for the strobes currently driven, from the model settings.
    function automatic logic [NC-1:0] exp_inc();
        logic [NC-1:0] r = '0;
        for (int c = 0; c < NC; c++) begin
            int g = int'(m_grp[c]);
            logic [7:0] code = ev_code[g*8 +: 8];
            logic [1:0] s = ev_sub[g*2 +: 2];
            logic match, subok, orgok;
            match = (g == 7) ? (!code[7] && code[6:0] == m_sel[62:56])
                             : (code == m_sel[g*8 +: 8]);
            subok = (s != 2'd3) && m_sub[c][s];
            orgok = ev_noid[g] ? m_org[c][2] : m_org[c][ev_origin[g]];
            r[c] = ev_valid[g] && m_sel[63] && match && (code != 8'hFE) && subok && orgok;
        end
        return r;
    endfunction

    task automatic clear_ev();
        ev_valid = '0; ev_code = '0; ev_origin = '0; ev_noid = '0; ev_sub = '0;
    endtask

    task automatic put_ev(input int g, input logic [7:0] code, input logic org,
                          input logic noid, input logic [1:0] sub);
        ev_valid[g] = 1'b1;
        ev_code[g*8 +: 8] = code;
        ev_origin[g] = org;
        ev_noid[g] = noid;
        ev_sub[g*2 +: 2] = sub;
    endtask

    task automatic fire(input string req, input int g, input logic [7:0] code,
                        input logic org, input logic noid, input logic [1:0] sub,
                        input logic [NC-1:0] want);
        logic [NC-1:0] e;
        put_ev(g, code, org, noid, sub);
        e = exp_inc();
        @(negedge clk);
        chk(req, 64'(ctr_inc), 64'(e));
        chk(req, 64'(ctr_inc), 64'(want));
        clear_ev();
    endtask

    task automatic wr_all(input logic [63:0] d);
        sel_wr_all = 1'b1; sel_wr_data = d;
        @(negedge clk);
        sel_wr_all = 1'b0;
        m_sel = d;
    endtask

    task automatic wr_fld(input int g, input logic [7:0] code);
        sel_fld_we = 1'b1; sel_fld_grp = 3'(g); sel_fld_code = code;
        @(negedge clk);
        sel_fld_we = 1'b0;
        m_sel[g*8 +: 8] = code;
        m_sel[63] = 1'b1;
    endtask

    task automatic cfg_ctr(input int c, input logic is_filt, input logic [2:0] grp,
                           input logic [2:0] sub, input logic [2:0] org);
        ctr_cfg_we = 1'b1; ctr_cfg_idx = 3'(c); ctr_cfg_is_filt = is_filt;
        ctr_cfg_grp = grp; ctr_cfg_sub_en = sub; ctr_cfg_org_en = org;
        @(negedge clk);
        ctr_cfg_we = 1'b0;
        if (is_filt) begin m_sub[c] = sub; m_org[c] = org; end
        else m_grp[c] = grp;
    endtask

    task automatic t_reset();
        chk("R1 sel_word after reset", sel_word, 64'h0);
        chk("R1 ctr_inc after reset", 64'(ctr_inc), 64'h0);
        fire("R1/R4 strobe while disarmed", 0, 8'h00, 1'b0, 1'b0, 2'd0, '0);
    endtask

    task automatic t_route();
        for (int c = 0; c < NC; c++) begin
            cfg_ctr(c, 1'b0, 3'(c), 3'b000, 3'b000);
            cfg_ctr(c, 1'b1, 3'b000, 3'b111, 3'b111);
        end
        wr_all(64'hA566_5544_3322_1100);
        chk("R2 whole load", sel_word, 64'hA566_5544_3322_1100);
        for (int g = 0; g < 7; g++)
            fire("R5 matching code per group", g, m_sel[g*8 +: 8], 1'b0, 1'b0, 2'd0, NC'(1) << g);
        fire("R5 group 7 match", 7, 8'h25, 1'b1, 1'b0, 2'd2, NC'(1) << 7);
        fire("R5 non-matching code", 3, 8'h34, 1'b0, 1'b0, 2'd0, '0);
    endtask

    task automatic t_field();
        wr_fld(3, 8'h5A);
        chk("R3 field update keeps others", sel_word, 64'hA566_5544_5A22_1100);
        fire("R3 new field live", 3, 8'h5A, 1'b0, 1'b0, 2'd1, NC'(1) << 3);
        wr_all(m_sel & ~(64'h1 << 63));
        wr_fld(1, 8'h3C);
        chk("R3 field update arms enable", sel_word, 64'hA566_5544_5A22_3C00);
    endtask

    task automatic t_disable();
        wr_all(m_sel & ~(64'h1 << 63));
        fire("R4 disabled match", 1, 8'h3C, 1'b0, 1'b0, 2'd0, '0);
        wr_all(m_sel | (64'h1 << 63));
        fire("R4 re-enabled match", 1, 8'h3C, 1'b0, 1'b0, 2'd0, NC'(1) << 1);
    endtask

    task automatic t_reserved();
        wr_fld(2, 8'hFE);
        fire("R6 cycle code never counts", 2, 8'hFE, 1'b0, 1'b0, 2'd0, '0);
    endtask

    task automatic t_grp7();
        wr_fld(7, 8'hC5);
        chk("R7 group 7 field seven bits", 64'(sel_word[62:56]), 64'h45);
        fire("R7 group 7 low code matches", 7, 8'h45, 1'b0, 1'b0, 2'd0, NC'(1) << 7);
        fire("R7 group 7 high bit rejected", 7, 8'hC5, 1'b0, 1'b0, 2'd0, '0);
    endtask

    task automatic t_filter();
        cfg_ctr(0, 1'b1, 3'b000, 3'b010, 3'b111);
        fire("R8 subunit 0 blocked", 0, 8'h00, 1'b0, 1'b0, 2'd0, '0);
        fire("R8 subunit 1 passes", 0, 8'h00, 1'b0, 1'b0, 2'd1, NC'(1));
        fire("R8 subunit 2 blocked", 0, 8'h00, 1'b0, 1'b0, 2'd2, '0);
        cfg_ctr(0, 1'b1, 3'b000, 3'b111, 3'b111);
        fire("R8 subunit 3 never passes", 0, 8'h00, 1'b0, 1'b0, 2'd3, '0);
        cfg_ctr(0, 1'b1, 3'b000, 3'b111, 3'b101);
        fire("R9 origin 0 passes", 0, 8'h00, 1'b0, 1'b0, 2'd0, NC'(1));
        fire("R9 origin 1 blocked", 0, 8'h00, 1'b1, 1'b0, 2'd0, '0);
        fire("R9 no-id passes", 0, 8'h00, 1'b1, 1'b1, 2'd0, NC'(1));
        cfg_ctr(0, 1'b1, 3'b000, 3'b111, 3'b011);
        fire("R9 no-id blocked", 0, 8'h00, 1'b0, 1'b1, 2'd0, '0);
        cfg_ctr(0, 1'b1, 3'b000, 3'b111, 3'b111);
    endtask

    task automatic t_shared();
        logic [NC-1:0] e;
        cfg_ctr(1, 1'b0, 3'd4, 3'b000, 3'b000);
        cfg_ctr(2, 1'b0, 3'd4, 3'b000, 3'b000);
        fire("R10 shared group pulses together", 4, 8'h44, 1'b0, 1'b0, 2'd0, 8'b0001_0110);
        put_ev(0, 8'h00, 1'b0, 1'b0, 2'd0);
        put_ev(5, 8'h55, 1'b1, 1'b0, 2'd2);
        e = exp_inc();
        @(negedge clk);
        chk("R10 simultaneous groups", 64'(ctr_inc), 64'(e));
        chk("R10 simultaneous groups", 64'(ctr_inc), 64'h21);
        clear_ev();
        cfg_ctr(1, 1'b0, 3'd1, 3'b000, 3'b000);
        cfg_ctr(2, 1'b0, 3'd2, 3'b000, 3'b000);
    endtask

    task automatic t_same_cycle();
        // Field rewrite and strobe of the old code in one cycle.
        put_ev(0, 8'h00, 1'b0, 1'b0, 2'd0);
        sel_fld_we = 1'b1; sel_fld_grp = 3'd0; sel_fld_code = 8'h77;
        @(negedge clk);
        sel_fld_we = 1'b0;
        chk("R12 old code counted during rewrite", 64'(ctr_inc), 64'h01);
        clear_ev();
        m_sel[7:0] = 8'h77;
        fire("R12 new code after rewrite", 0, 8'h77, 1'b0, 1'b0, 2'd0, NC'(1));
        fire("R12 old code after rewrite", 0, 8'h00, 1'b0, 1'b0, 2'd0, '0);
        // Whole load and field update together.
        sel_wr_all = 1'b1; sel_wr_data = 64'h8123_4567_89AB_CDEF;
        sel_fld_we = 1'b1; sel_fld_grp = 3'd2; sel_fld_code = 8'h11;
        @(negedge clk);
        sel_wr_all = 1'b0; sel_fld_we = 1'b0;
        m_sel = 64'h8123_4567_89AB_CDEF;
        chk("R2 whole load outranks field", sel_word, 64'h8123_4567_89AB_CDEF);
    endtask

    task automatic t_type_cfg();
        put_ev(6, m_sel[55:48], 1'b0, 1'b0, 2'd0);
        ctr_cfg_we = 1'b1; ctr_cfg_idx = 3'd3; ctr_cfg_is_filt = 1'b0; ctr_cfg_grp = 3'd6;
        @(negedge clk);
        ctr_cfg_we = 1'b0;
        chk("R11 group change not yet in force", 64'(ctr_inc), 64'h40);
        m_grp[3] = 3'd6;
        clear_ev();
        fire("R11 group change in force", 6, m_sel[55:48], 1'b0, 1'b0, 2'd0, 8'b0100_1000);
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin m_grp[c] = '0; m_sub[c] = '0; m_org[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_field();
        t_disable();
        t_reserved();
        t_grp7();
        t_filter();
        t_shared();
        t_same_cycle();
        t_type_cfg();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end
endmodule